// File: doc/BRIEF.md
# Per-Flow Receive Statistics Updater

This block computes the new counter words of one receive flow entry each time a received MSDU matches that flow. The caller reads the entry's current words from table storage and presents them with the packet's attributes and a strobe. One cycle later the block returns the rewritten words with a valid flag, and the caller writes them back. Each update also yields an aggregation-eligibility verdict for the packet.

A mode input chooses between two accounting schemes. In combined mode every packet counts toward a single set of counters. In split mode the same five words are shared between two MAC instances, so a field's meaning depends on which instance received the packet. A second input switches aggregation tracking off. When it is off, the aggregation fields stay at zero.

Eligibility tracking works as follows. The sequence field holds the sequence number expected next for the flow, which is the last packet's TCP sequence number plus its IP length. A new packet continues the running aggregate only when it arrives at that expected sequence.

Top module: `flow_stats_update`

## Requirements
- R1: `upd_valid` is high in exactly the cycle after a cycle with `upd_strobe` high, and low otherwise. The `new_*` words and `pkt_eligible` are registered and change only on a strobe.
- R2: On every update, `new_ts_word` equals the `now_ts` presented with the strobe.
- R3: Combined mode (`split_mode`=0):
  - the MSDU count in `cnt_word[31:8]` increments by one, modulo 2^24;
  - `byte_word` adds `pkt_bytes`, modulo 2^32.
- R4: Split mode (`split_mode`=1):
  - a MAC-0 packet (`pkt_mac`=0) increments `cnt_word[31:8]` and leaves `byte_word` unchanged;
  - a MAC-1 packet increments `byte_word[23:0]` (modulo 2^24) and leaves `cnt_word` unchanged.
- R5: A lane's aggregate state is its 7-bit count, its eligibility bit and its 16-bit cumulative length. A packet is eligible when all of the following hold:
  - the lane's count is neither 0 nor 127;
  - the packet's sequence, truncated to the lane's sequence width, equals the stored expected sequence.
  
  When the packet is eligible, the count increments, `pkt_ip_len` is added to the cumulative length (modulo 2^16), and the stored eligibility bit and `pkt_eligible` are both 1.
- R6: When the packet is not eligible and the count is below 127, the aggregate restarts: the count becomes 1, the cumulative length becomes `pkt_ip_len`, and the eligibility bit and `pkt_eligible` are 0.
- R7: A lane count of 127 forces a flush. The next packet restarts the aggregate as in R6, even when its sequence matches.
- R8: The expected sequence stored after an update is `pkt_seq + pkt_ip_len`. In combined mode it fills all 32 bits of `seq_word`. In split mode it is taken modulo 2^16 and written to the packet's MAC half.
- R9: Field positions:
  - combined mode: aggregate count in `cnt_word[6:0]`, eligibility in `cnt_word[7]`, cumulative length in `len_word[31:16]`, with `len_word[15:0]` passed through;
  - split mode, MAC 0: count in `cnt_word[6:0]`, eligibility in `cnt_word[7]`, length in `len_word[31:16]`, sequence in `seq_word[15:0]`;
  - split mode, MAC 1: count in `byte_word[30:24]`, eligibility in `byte_word[31]`, length in `len_word[15:0]`, sequence in `seq_word[31:16]`;
  - in split mode, the other MAC's halves are unchanged.
- R10: With `agg_en`=0, an update writes all zeros to `new_len_word`, `new_seq_word` and the packet lane's count and eligibility bits, and `pkt_eligible` is 0.
- R11: After synchronous active-low reset, `upd_valid`, `pkt_eligible` and all `new_*` words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_strobe | input | 1 | Request one update with the inputs of this cycle |
| split_mode | input | 1 | 0 = combined accounting, 1 = per-MAC split |
| agg_en | input | 1 | Enables aggregation tracking |
| pkt_mac | input | 1 | Source MAC instance of the packet |
| pkt_bytes | input | 16 | MSDU byte length |
| pkt_ip_len | input | 16 | Packet IP length |
| pkt_seq | input | 32 | Packet TCP sequence number |
| now_ts | input | 32 | Arrival time |
| cnt_word | input | 32 | Current count/aggregate word |
| byte_word | input | 32 | Current byte word |
| len_word | input | 32 | Current cumulative-length word |
| seq_word | input | 32 | Current expected-sequence word |
| upd_valid | output | 1 | Updated words are valid |
| pkt_eligible | output | 1 | Packet continued the aggregate |
| new_cnt_word | output | 32 | Updated count/aggregate word |
| new_byte_word | output | 32 | Updated byte word |
| new_ts_word | output | 32 | Updated timestamp word |
| new_len_word | output | 32 | Updated cumulative-length word |
| new_seq_word | output | 32 | Updated expected-sequence word |

## Verification
The block is stateless between strobes. Any wrong decision therefore shows up in the output words of the very next cycle after that strobe and nowhere else.

Faults appear at the ports as follows:
- A mode or lane mux error puts a field into the wrong half or leaves the other MAC's half modified.
- An eligibility error shows as a count of 1 where an increment was due, or as a wrong `pkt_eligible`.

Wrap and saturation errors need the boundary values 0xFFFFFF and 127 to be presented. The bench forces these values directly.

// File: rtl/flow_stats_pkg.sv
// Shared widths and the aggregate-state record of one accounting lane.
// Assumes the fixed 32-bit word layout of a flow entry.
package flow_stats_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 24;
    localparam int AGG_W  = 7;
    localparam int LEN_W  = 16;
    localparam int HALF_W = WORD_W / 2;
    localparam int TAG_W  = AGG_W + 1;

    typedef struct packed {
        logic             elig;
        logic [AGG_W-1:0] cnt;
        logic [LEN_W-1:0] cum;
    } agg_state_t;
endpackage

// File: rtl/flow_agg_lane.sv
// Aggregation tracker for one lane. It decides whether a packet continues
// the running aggregate and returns the new aggregate state and the new
// expected sequence. SEQ_W is 32 for combined mode and 16 for a split half.
// Assumes old_seq holds the sequence expected next, right-aligned.
module flow_agg_lane
    import flow_stats_pkg::*;
#(
    parameter int SEQ_W = WORD_W
) (
    input  logic                 en,
    input  agg_state_t           old_st,
    input  logic [SEQ_W-1:0]     old_seq,
    input  logic [SEQ_W-1:0]     pkt_seq,
    input  logic [LEN_W-1:0]     pkt_len,
    output agg_state_t           new_st,
    output logic [SEQ_W-1:0]     new_seq
);
    localparam logic [AGG_W-1:0] AGG_MAX = '1;

    logic cont;

    // Continue only an open, non-full aggregate at the expected sequence
    always_comb cont = (old_st.cnt != '0) && (old_st.cnt != AGG_MAX) && (pkt_seq == old_seq);

    // Next aggregate state: extend, restart, or zero when disabled
    always_comb begin
        if (!en) begin
            new_st  = '0;
            new_seq = '0;
        end else begin
            if (cont) begin
                new_st.elig = 1'b1;
                new_st.cnt  = old_st.cnt + AGG_W'(1);
                new_st.cum  = old_st.cum + pkt_len;
            end else begin
                new_st.elig = 1'b0;
                new_st.cnt  = AGG_W'(1);
                new_st.cum  = pkt_len;
            end
            new_seq = pkt_seq + SEQ_W'(pkt_len);
        end
    end
endmodule

// File: rtl/flow_word_merge.sv
// Places the lane results and counter increments into the five entry
// words according to mode and source MAC. Fields that the packet does not
// own pass through unchanged.
// Assumes the lane inputs were already selected for the same MAC.
module flow_word_merge
    import flow_stats_pkg::*;
(
    input  logic              split_mode,
    input  logic              agg_en,
    input  logic              pkt_mac,
    input  logic [LEN_W-1:0]  pkt_bytes,
    input  logic [WORD_W-1:0] cnt_word,
    input  logic [WORD_W-1:0] byte_word,
    input  logic [WORD_W-1:0] len_word,
    input  logic [WORD_W-1:0] seq_word,
    input  agg_state_t        full_st,
    input  logic [WORD_W-1:0] full_seq,
    input  agg_state_t        half_st,
    input  logic [HALF_W-1:0] half_seq,
    output logic [WORD_W-1:0] nxt_cnt,
    output logic [WORD_W-1:0] nxt_byte,
    output logic [WORD_W-1:0] nxt_len,
    output logic [WORD_W-1:0] nxt_seq,
    output logic              nxt_elig
);
    logic [CNT_W-1:0] cnt0_inc;
    logic [CNT_W-1:0] cnt1_inc;

    // Modulo-2^24 increments of the two MSDU counters
    always_comb begin
        cnt0_inc = cnt_word[WORD_W-1:TAG_W] + CNT_W'(1);
        cnt1_inc = byte_word[CNT_W-1:0] + CNT_W'(1);
    end

    // Route each result into its word position
    always_comb begin
        nxt_cnt  = cnt_word;
        nxt_byte = byte_word;
        nxt_len  = len_word;
        nxt_seq  = seq_word;
        if (!split_mode) begin
            nxt_cnt              = {cnt0_inc, full_st.elig, full_st.cnt};
            nxt_byte             = byte_word + WORD_W'(pkt_bytes);
            nxt_len[WORD_W-1:HALF_W] = full_st.cum;
            nxt_seq              = full_seq;
            nxt_elig             = full_st.elig;
        end else if (!pkt_mac) begin
            nxt_cnt              = {cnt0_inc, half_st.elig, half_st.cnt};
            nxt_len[WORD_W-1:HALF_W] = half_st.cum;
            nxt_seq[HALF_W-1:0]  = half_seq;
            nxt_elig             = half_st.elig;
        end else begin
            nxt_byte             = {half_st.elig, half_st.cnt, cnt1_inc};
            nxt_len[HALF_W-1:0]  = half_st.cum;
            nxt_seq[WORD_W-1:HALF_W] = half_seq;
            nxt_elig             = half_st.elig;
        end
        if (!agg_en) begin
            nxt_len = '0;
            nxt_seq = '0;
        end
    end
endmodule

// File: rtl/flow_stats_update.sv
// Read-modify-write updater for one flow entry's statistics words.
// A strobe samples the current words and the packet attributes. The
// rewritten words and the eligibility verdict appear one cycle later
// with upd_valid. Assumes the caller holds off conflicting writes.
module flow_stats_update
    import flow_stats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_strobe,
    input  logic              split_mode,
    input  logic              agg_en,
    input  logic              pkt_mac,
    input  logic [15:0]       pkt_bytes,
    input  logic [15:0]       pkt_ip_len,
    input  logic [31:0]       pkt_seq,
    input  logic [31:0]       now_ts,
    input  logic [31:0]       cnt_word,
    input  logic [31:0]       byte_word,
    input  logic [31:0]       len_word,
    input  logic [31:0]       seq_word,
    output logic              upd_valid,
    output logic              pkt_eligible,
    output logic [31:0]       new_cnt_word,
    output logic [31:0]       new_byte_word,
    output logic [31:0]       new_ts_word,
    output logic [31:0]       new_len_word,
    output logic [31:0]       new_seq_word
);
    agg_state_t        full_old, half_old, full_new, half_new;
    logic [HALF_W-1:0] half_old_seq, half_new_seq;
    logic [WORD_W-1:0] full_new_seq;
    logic [WORD_W-1:0] nxt_cnt, nxt_byte, nxt_len, nxt_seq;
    logic              nxt_elig;

    // Gather the combined-mode lane state from its fixed positions
    always_comb full_old = '{elig: cnt_word[AGG_W], cnt: cnt_word[AGG_W-1:0],
                             cum: len_word[WORD_W-1:HALF_W]};

    // Select the split-mode lane state of the packet's MAC
    always_comb begin
        if (!pkt_mac) begin
            half_old     = '{elig: cnt_word[AGG_W], cnt: cnt_word[AGG_W-1:0],
                             cum: len_word[WORD_W-1:HALF_W]};
            half_old_seq = seq_word[HALF_W-1:0];
        end else begin
            half_old     = '{elig: byte_word[WORD_W-1], cnt: byte_word[WORD_W-2:CNT_W],
                             cum: len_word[HALF_W-1:0]};
            half_old_seq = seq_word[WORD_W-1:HALF_W];
        end
    end

    flow_agg_lane #(.SEQ_W(WORD_W)) i_lane_full (
        .en      (agg_en),
        .old_st  (full_old),
        .old_seq (seq_word),
        .pkt_seq (pkt_seq),
        .pkt_len (pkt_ip_len),
        .new_st  (full_new),
        .new_seq (full_new_seq)
    );

    flow_agg_lane #(.SEQ_W(HALF_W)) i_lane_half (
        .en      (agg_en),
        .old_st  (half_old),
        .old_seq (half_old_seq),
        .pkt_seq (pkt_seq[HALF_W-1:0]),
        .pkt_len (pkt_ip_len),
        .new_st  (half_new),
        .new_seq (half_new_seq)
    );

    flow_word_merge i_merge (
        .split_mode (split_mode),
        .agg_en     (agg_en),
        .pkt_mac    (pkt_mac),
        .pkt_bytes  (pkt_bytes),
        .cnt_word   (cnt_word),
        .byte_word  (byte_word),
        .len_word   (len_word),
        .seq_word   (seq_word),
        .full_st    (full_new),
        .full_seq   (full_new_seq),
        .half_st    (half_new),
        .half_seq   (half_new_seq),
        .nxt_cnt    (nxt_cnt),
        .nxt_byte   (nxt_byte),
        .nxt_len    (nxt_len),
        .nxt_seq    (nxt_seq),
        .nxt_elig   (nxt_elig)
    );

    // Register the update result one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid     <= 1'b0;
            pkt_eligible  <= 1'b0;
            new_cnt_word  <= '0;
            new_byte_word <= '0;
            new_ts_word   <= '0;
            new_len_word  <= '0;
            new_seq_word  <= '0;
        end else begin
            upd_valid <= upd_strobe;
            if (upd_strobe) begin
                pkt_eligible  <= nxt_elig;
                new_cnt_word  <= nxt_cnt;
                new_byte_word <= nxt_byte;
                new_ts_word   <= now_ts;
                new_len_word  <= nxt_len;
                new_seq_word  <= nxt_seq;
            end
        end
    end
endmodule

// File: rtl/flow_stats_checker.sv
// Temporal properties of the updater, attached by bind.
module flow_stats_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_strobe,
    input logic        split_mode,
    input logic        agg_en,
    input logic [31:0] now_ts,
    input logic [31:0] cnt_word,
    input logic        upd_valid,
    input logic        pkt_eligible,
    input logic [31:0] new_cnt_word,
    input logic [31:0] new_ts_word,
    input logic [31:0] new_len_word,
    input logic [31:0] new_seq_word
);
    // R1
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |=> upd_valid);
    // R1
    valid_only_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe |=> !upd_valid);
    // R1
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe |=> $stable(new_cnt_word) && $stable(new_seq_word));
    // R2
    ts_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |=> new_ts_word == $past(now_ts));
    // R3
    combined_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe && !split_mode |=> new_cnt_word[31:8] == $past(cnt_word[31:8]) + 24'd1);
    // R10
    agg_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe && !agg_en |=> new_len_word == '0 && new_seq_word == '0 && !pkt_eligible);
    // R5
    combined_agg_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe && agg_en && !split_mode |=> new_cnt_word[6:0] != 7'd0);
endmodule

bind flow_stats_update flow_stats_checker i_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_strobe   (upd_strobe),
    .split_mode   (split_mode),
    .agg_en       (agg_en),
    .now_ts       (now_ts),
    .cnt_word     (cnt_word),
    .upd_valid    (upd_valid),
    .pkt_eligible (pkt_eligible),
    .new_cnt_word (new_cnt_word),
    .new_ts_word  (new_ts_word),
    .new_len_word (new_len_word),
    .new_seq_word (new_seq_word)
);

// File: tb/test_flow_stats_update.sv
module test_flow_stats_update;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_strobe = 1'b0;
    logic        split_mode = 1'b0;
    logic        agg_en = 1'b1;
    logic        pkt_mac = 1'b0;
    logic [15:0] pkt_bytes = '0;
    logic [15:0] pkt_ip_len = '0;
    logic [31:0] pkt_seq = '0;
    logic [31:0] now_ts = '0;
    logic [31:0] cnt_word = '0;
    logic [31:0] byte_word = '0;
    logic [31:0] len_word = '0;
    logic [31:0] seq_word = '0;
    logic        upd_valid, pkt_eligible;
    logic [31:0] new_cnt_word, new_byte_word, new_ts_word, new_len_word, new_seq_word;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_stats_update i_flow_stats_update (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Aggregate lane model; sw = 32 or 16, old_seq right-aligned
    function automatic void lane_m(input int sw, input logic en, input logic [6:0] oc,
                                   input logic [15:0] ocum, input logic [31:0] oseq,
                                   input logic [31:0] ps, input logic [15:0] il,
                                   output logic e, output logic [6:0] c,
                                   output logic [15:0] cum, output logic [31:0] sq);
        logic [31:0] m = (sw == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        if (!en) begin
            e = 0; c = 0; cum = 0; sq = 0;
        end else begin
            if (oc != 0 && oc != 7'd127 && ((ps & m) == (oseq & m))) begin
                e = 1; c = oc + 7'd1; cum = ocum + il;
            end else begin
                e = 0; c = 7'd1; cum = il;
            end
            sq = (ps + {16'h0, il}) & m;
        end
    endfunction

    logic [31:0] x_cnt, x_byte, x_len, x_seq;
    logic        x_elig;

    task automatic model();
        logic e; logic [6:0] c; logic [15:0] cum; logic [31:0] sq;
        x_cnt = cnt_word; x_byte = byte_word; x_len = len_word; x_seq = seq_word;
        if (!split_mode) begin
            lane_m(32, agg_en, cnt_word[6:0], len_word[31:16], seq_word, pkt_seq, pkt_ip_len, e, c, cum, sq);
            x_cnt = {cnt_word[31:8] + 24'd1, e, c};
            x_byte = byte_word + {16'h0, pkt_bytes};
            x_len[31:16] = cum; x_seq = sq;
        end else if (!pkt_mac) begin
            lane_m(16, agg_en, cnt_word[6:0], len_word[31:16], {16'h0, seq_word[15:0]}, pkt_seq, pkt_ip_len, e, c, cum, sq);
            x_cnt = {cnt_word[31:8] + 24'd1, e, c};
            x_len[31:16] = cum; x_seq[15:0] = sq[15:0];
        end else begin
            lane_m(16, agg_en, byte_word[30:24], len_word[15:0], {16'h0, seq_word[31:16]}, pkt_seq, pkt_ip_len, e, c, cum, sq);
            x_byte = {e, c, byte_word[23:0] + 24'd1};
            x_len[15:0] = cum; x_seq[31:16] = sq[15:0];
        end
        if (!agg_en) begin x_len = 0; x_seq = 0; end
        x_elig = e;
    endtask

    // Present one update, then compare every output against the model
    task automatic apply(input string tag_cnt, input string tag_agg);
        @(negedge clk);
        model();
        upd_strobe = 1'b1;
        @(negedge clk);
        upd_strobe = 1'b0;
        check("R1 valid", {31'h0, upd_valid}, 32'h1);
        check("R2 ts", new_ts_word, now_ts);
        check(tag_cnt, new_cnt_word, x_cnt);
        check(tag_cnt, new_byte_word, x_byte);
        check(tag_agg, new_len_word, x_len);
        check(tag_agg, new_seq_word, x_seq);
        check(tag_agg, {31'h0, pkt_eligible}, {31'h0, x_elig});
        @(negedge clk);
        check("R1 idle", {31'h0, upd_valid}, 32'h0);
    endtask

    task automatic set_all(input logic sm, input logic mac, input logic en);
        split_mode = sm; pkt_mac = mac; agg_en = en;
        pkt_bytes = 16'($urandom); pkt_ip_len = 16'($urandom);
        pkt_seq = $urandom; now_ts = $urandom;
        cnt_word = $urandom; byte_word = $urandom;
        len_word = $urandom; seq_word = $urandom;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 valid", {31'h0, upd_valid}, 32'h0);
        check("R11 elig", {31'h0, pkt_eligible}, 32'h0);
        check("R11 cnt", new_cnt_word, 32'h0);
        check("R11 seq", new_seq_word, 32'h0);
        rst_n = 1'b1;

        // R3 counter and byte wrap
        set_all(0, 0, 1);
        cnt_word[31:8] = 24'hFF_FFFF; byte_word = 32'hFFFF_FFF0; pkt_bytes = 16'h20;
        apply("R3 wrap", "R5");
        // R5 extend to 127 at the expected sequence
        set_all(0, 0, 1);
        cnt_word[6:0] = 7'd126; pkt_seq = seq_word;
        apply("R3", "R5 extend to 127");
        // R7 full aggregate flushes despite a match
        set_all(0, 0, 1);
        cnt_word[6:0] = 7'd127; pkt_seq = seq_word;
        apply("R3", "R7 flush");
        // R6 count zero restarts
        set_all(0, 0, 1);
        cnt_word[6:0] = 7'd0; pkt_seq = seq_word;
        apply("R3", "R6 empty");
        // R6 mismatch restarts
        set_all(0, 0, 1);
        cnt_word[6:0] = 7'd5; pkt_seq = seq_word + 32'd1;
        apply("R3", "R6 mismatch");
        // R8 split half-sequence wrap, MAC 1
        set_all(1, 1, 1);
        byte_word[30:24] = 7'd3; pkt_seq[15:0] = seq_word[31:16];
        pkt_seq[15:0] = 16'hFFF0; seq_word[31:16] = 16'hFFF0; pkt_ip_len = 16'h0040;
        apply("R4 mac1", "R8 R9 half wrap");
        // R4 split MAC 1 count wrap, cnt_word untouched
        set_all(1, 1, 1);
        byte_word[23:0] = 24'hFF_FFFF;
        apply("R4 mac1 wrap", "R9");
        // R10 disabled aggregation in both modes
        set_all(0, 0, 0);
        apply("R3", "R10 off combined");
        set_all(1, 1, 0);
        apply("R4", "R10 off split");

        for (int i = 0; i < N_RANDOM; i++) begin
            logic sm, mac, en;
            sm = 1'($urandom); mac = 1'($urandom); en = ($urandom % 8) != 0;
            set_all(sm, mac, en);
            if ($urandom % 2) begin
                if (!sm) pkt_seq = seq_word;
                else if (!mac) pkt_seq[15:0] = seq_word[15:0];
                else pkt_seq[15:0] = seq_word[31:16];
            end
            if (!sm) apply("R3 rand", en ? "R5 R6 R8 R9 rand" : "R10 rand");
            else apply("R4 rand", en ? "R5 R6 R8 R9 rand" : "R10 rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule